// File: doc/BRIEF.md
# Indirect Radio Register Access Bridge

This block lets a host reach a bank of 8-bit radio configuration registers through one 32-bit command/status word. The host writes a single word that carries the register number, the data byte, a direction flag and a busy flag. When the bridge is idle and the busy flag in the written word is set, the bridge accepts the command and raises busy. It then runs a transfer of fixed length toward the radio register bank, which is modelled here as an internal array. When the transfer ends, busy drops. A write has then been stored; a read has placed the register contents in the low byte of the status word.

The host polls busy before it issues a command, and again after a read before it uses the data. The radio side can hold the transfer off with a stall input. If a transfer does not finish within a bounded number of cycles, the bridge abandons it. The next status read then returns all ones, so a read performed this way yields 0xFF. A command written while a transfer is still running is dropped and leaves a sticky overrun mark, which a status read clears.

Top module: `rfb_bridge`

## Requirements
- R1: After reset the status word reads 0x00000000 with busy (bit 17) clear, and every radio register reads back as 0x00.
- R2: A host write whose bit 17 is 1, issued while the bridge is idle, is accepted as a command. Its fields are: data in bits 7:0, register number in bits 12:8, and the write flag in bit 16 (1 = write, 0 = read). Busy reads 1 in the cycle after acceptance.
- R3: With the stall input low throughout, busy stays 1 for exactly LATENCY clock cycles after acceptance (default 24) and then reads 0.
- R4: A completed write command stores its data byte in the addressed register. While busy, and after completion, the status word shows the command's data, register number and write flag.
- R5: When a read command completes, bits 7:0 of the status word hold the addressed register's value, bits 12:8 hold its register number and bit 16 reads 0.
- R6: A command (bit 17 = 1) written while busy is 1 is dropped and leaves every register unchanged. It sets overrun (bit 31) from the next cycle. A host status read clears overrun after returning it.
- R7: Each cycle in which the stall input is high during a transfer delays completion by one cycle.
- R8: A transfer that has not completed TIMEOUT cycles after acceptance (default 64) is abandoned. Busy clears, a write is not stored, and the next status read returns 0xFFFFFFFF (data 0xFF). That read clears the all-ones view.
- R9: A host write with bit 17 equal to 0 starts nothing, leaves busy at 0 and changes neither the status word nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host writes the command word this cycle |
| host_rd | input | 1 | Host reads the status word this cycle (clears the sticky marks) |
| host_wdata | input | 32 | Command word from the host |
| host_rdata | output | 32 | Status word seen by the host |
| link_stall | input | 1 | Radio side holds the current transfer off this cycle |

## Verification
The assertions check, on every cycle, that busy stays within its latency and timeout windows. They also check that busy falls only on a completion or an abort event, that a stall freezes the progress counter, that an accepted command raises busy, that a command written while busy raises overrun and leaves the latched fields stable, and that a stored write lands in the array. The latency figures, the contents read back after a mix of random writes and reads, the all-ones word after an abort and its one-shot clearing, and the fact that dropped commands leave the target register untouched can only be shown by the bench's scenarios, which compare the host-visible status word against a model of the register bank.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

  // Field positions of the command/status word. These are fixed by the
  // protocol the host software follows.
  localparam int DATA_LSB = 0;
  localparam int DATA_W   = 8;
  localparam int REG_LSB  = 8;
  localparam int REG_W    = 5;
  localparam int WR_BIT   = 16;
  localparam int BUSY_BIT = 17;
  localparam int OVR_BIT  = 31;

  typedef struct packed {
    logic [REG_W-1:0]  regnum;
    logic [DATA_W-1:0] data;
    logic              wr;
  } rfb_cmd_t;

  // Pull the command fields out of a host word.
  function automatic rfb_cmd_t unpack_cmd(logic [31:0] word);
    rfb_cmd_t c;
    c.regnum = word[REG_LSB +: REG_W];
    c.data   = word[DATA_LSB +: DATA_W];
    c.wr     = word[WR_BIT];
    return c;
  endfunction

  // Assemble the status word seen by the host.
  function automatic logic [31:0] pack_status(rfb_cmd_t c, logic bsy, logic ovr);
    logic [31:0] w;
    w = '0;
    w[DATA_LSB +: DATA_W] = c.data;
    w[REG_LSB +: REG_W]   = c.regnum;
    w[WR_BIT]             = c.wr;
    w[BUSY_BIT]           = bsy;
    w[OVR_BIT]            = ovr;
    return w;
  endfunction

endpackage

// File: rtl/rfb_regfile.sv
module rfb_regfile #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (int'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    if (DEPTH == (1 << AW)) begin : g_full
      assign rdata = mem[raddr];
    end else begin : g_partial
      assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
    end
  endgenerate

  // A stored write is visible at its address one cycle later (R4).
  assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (int'(waddr) < DEPTH)) |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/rfb_xfer_engine.sv
module rfb_xfer_engine #(
  parameter int LATENCY = 24,
  parameter int TIMEOUT = 64,
  localparam int CW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic link_stall,
  output logic busy,
  output logic done_evt,
  output logic tmo_evt
);

  logic [CW-1:0] step_q;
  logic [CW-1:0] age_q;
  logic          last_step;
  logic          age_out;

  initial assert_param_R8: assert (TIMEOUT > LATENCY && LATENCY >= 1)
    else $error("TIMEOUT must exceed LATENCY");

  assign last_step = busy && !link_stall && (step_q == CW'(LATENCY - 1));
  assign age_out   = busy && (age_q == CW'(TIMEOUT - 1));
  assign done_evt  = last_step;
  assign tmo_evt   = age_out && !last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step_q <= '0;
      age_q  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        step_q <= '0;
        age_q  <= '0;
      end
    end else if (done_evt || tmo_evt) begin
      busy <= 1'b0;
    end else begin
      age_q <= age_q + 1'b1;
      if (!link_stall) step_q <= step_q + 1'b1;
    end
  end

  assert_lat_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(step_q) < LATENCY));

  assert_tmo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(age_q) < TIMEOUT));

  assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_evt || tmo_evt));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && link_stall && !tmo_evt) |=> $stable(step_q));

endmodule

// File: rtl/rfb_bridge.sv
module rfb_bridge #(
  parameter int LATENCY = 24,
  parameter int TIMEOUT = 64,
  parameter int NREG    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        link_stall
);
  import rfb_pkg::*;

  // Named events, brought out for the assertions.
  logic     cmd_valid;
  logic     accept;
  logic     collide;
  logic     busy;
  logic     done_evt;
  logic     tmo_evt;
  logic     rf_we;
  logic [DATA_W-1:0] rf_rdata;

  rfb_cmd_t cur_q;
  logic     ovr_q;
  logic     ones_q;

  assign cmd_valid = host_wr && host_wdata[BUSY_BIT];
  assign accept    = cmd_valid && !busy;
  assign collide   = cmd_valid && busy;
  assign rf_we     = done_evt && cur_q.wr;

  rfb_xfer_engine #(
    .LATENCY (LATENCY),
    .TIMEOUT (TIMEOUT)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cmd_valid),
    .link_stall (link_stall),
    .busy       (busy),
    .done_evt   (done_evt),
    .tmo_evt    (tmo_evt)
  );

  rfb_regfile #(
    .DEPTH (NREG),
    .DW    (DATA_W),
    .AW    (REG_W)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (cur_q.regnum),
    .wdata (cur_q.data),
    .raddr (cur_q.regnum),
    .rdata (rf_rdata)
  );

  // Latched command; the data field takes the read result on completion.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (accept) begin
      cur_q <= unpack_cmd(host_wdata);
    end else if (done_evt && !cur_q.wr) begin
      cur_q.data <= rf_rdata;
    end
  end

  // Sticky overrun: a set wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)        ovr_q <= 1'b0;
    else if (collide)  ovr_q <= 1'b1;
    else if (host_rd)  ovr_q <= 1'b0;
  end

  // One-shot all-ones view after an abandoned transfer.
  always_ff @(posedge clk) begin
    if (!rst_n)                 ones_q <= 1'b0;
    else if (tmo_evt)           ones_q <= 1'b1;
    else if (host_rd || accept) ones_q <= 1'b0;
  end

  assign host_rdata = ones_q ? '1 : pack_status(cur_q, busy, ovr_q);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> ovr_q);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cur_q.regnum) && $stable(cur_q.wr)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !busy) |=> !busy);

endmodule

// File: tb/tb_rfb_bridge.sv
`timescale 1ns/1ps
module tb_rfb_bridge;
  localparam int LAT = 24;
  localparam int TMO = 64;
  localparam int FOREVER = 1000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        link_stall = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] model [32];

  always #2.5 clk = ~clk;

  rfb_bridge #(.LATENCY(LAT), .TIMEOUT(TMO), .NREG(32)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .link_stall(link_stall)
  );

  // Command word built independently: data 7:0, reg 12:8, write 16, busy 17.
  function automatic logic [31:0] cmd_word(logic [4:0] r, logic [7:0] d, logic w);
    return (32'(d)) | (32'(r) << 8) | (32'(w) << 16) | (32'h1 << 17);
  endfunction

  function automatic logic [31:0] done_word(logic [4:0] r, logic [7:0] d, logic w, logic ov);
    return (32'(d)) | (32'(r) << 8) | (32'(w) << 16) | (32'(ov) << 31);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_status(output logic [31:0] v);
    v = host_rdata;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // Issue a word, then count busy cycles; stall held for the first k steps.
  task automatic run_cmd(logic [31:0] w, int k, output int n, output logic [31:0] fin);
    link_stall = (k > 0);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
    n = 0;
    while (host_rdata[17] && host_rdata != '1 && n < 2000) begin
      if (n == k) link_stall = 1'b0;
      n++;
      @(negedge clk);
    end
    link_stall = 1'b0;
    fin = host_rdata;
  endtask

  task automatic do_read(logic [4:0] r, string req);
    int n;
    logic [31:0] fin;
    logic [31:0] s;
    run_cmd(cmd_word(r, 8'h00, 1'b0), 0, n, fin);
    rd_status(s);
    check(req, s, done_word(r, model[r], 1'b0, 1'b0));
  endtask

  task automatic do_write(logic [4:0] r, logic [7:0] d, string req);
    int n;
    logic [31:0] fin;
    run_cmd(cmd_word(r, d, 1'b1), 0, n, fin);
    model[r] = d;
    check(req, fin, done_word(r, d, 1'b1, 1'b0));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic [31:0] fin;
    logic [31:0] s;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 status", host_rdata, 32'h0);
    do_read(5'd31, "R1 reg31 zero");

    // R2/R3/R4: write latency and echo
    run_cmd(cmd_word(5'd3, 8'h5C, 1'b1), 0, n, fin);
    model[3] = 8'h5C;
    check("R3 latency", 32'(n), 32'(LAT));
    check("R4 write echo", fin, done_word(5'd3, 8'h5C, 1'b1, 1'b0));
    do_read(5'd3, "R5 readback");
    do_write(5'd0, 8'hFF, "R2 reg0");
    do_write(5'd31, 8'h81, "R2 reg31");
    do_read(5'd0, "R5 reg0");
    do_read(5'd31, "R5 reg31");

    // R9: write with busy flag clear does nothing
    host_wr = 1'b1;
    host_wdata = done_word(5'd3, 8'h11, 1'b1, 1'b0);
    @(negedge clk);
    host_wr = 1'b0;
    @(negedge clk);
    check("R9 no busy", 32'(host_rdata[17]), 32'h0);
    check("R9 status kept", host_rdata, done_word(5'd31, 8'h81, 1'b0, 1'b0));
    do_read(5'd3, "R9 reg unchanged");

    // R7: stall lengthens the transfer
    run_cmd(cmd_word(5'd7, 8'h3A, 1'b1), 9, n, fin);
    model[7] = 8'h3A;
    check("R7 stalled latency", 32'(n), 32'(LAT + 9));
    do_read(5'd7, "R7 data");

    // R6: collision while busy
    link_stall = 1'b0;
    host_wr = 1'b1;
    host_wdata = cmd_word(5'd9, 8'hC3, 1'b1);
    @(negedge clk);
    host_wdata = cmd_word(5'd10, 8'h77, 1'b1);
    @(negedge clk);
    host_wr = 1'b0;
    model[9] = 8'hC3;
    check("R6 overrun bit", 32'(host_rdata[31]), 32'h1);
    while (host_rdata[17]) @(negedge clk);
    rd_status(s);
    check("R6 status after", s, done_word(5'd9, 8'hC3, 1'b1, 1'b1));
    rd_status(s);
    check("R6 cleared", 32'(s[31]), 32'h0);
    do_read(5'd10, "R6 dropped cmd");

    // R8: timeout, write dropped, all-ones once
    run_cmd(cmd_word(5'd7, 8'h99, 1'b1), FOREVER, n, fin);
    check("R8 abort cycles", 32'(n), 32'(TMO));
    rd_status(s);
    check("R8 all ones", s, 32'hFFFF_FFFF);
    rd_status(s);
    check("R8 view cleared", 32'(s[17]), 32'h0);
    do_read(5'd7, "R8 write not stored");
    run_cmd(cmd_word(5'd7, 8'h00, 1'b0), FOREVER, n, fin);
    rd_status(s);
    check("R8 read gives FF", 32'(s[7:0]), 32'hFF);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [4:0] r;
      logic [7:0] d;
      r = 5'($urandom_range(0, 31));
      d = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) do_write(r, d, "R4 random write");
      else do_read(r, "R5 random read");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule